// File: doc/BRIEF.md
# Hall-Commutated Three-Phase Bridge Controller

This block turns three digitized Hall sensor levels into gate commands for a three-phase bipolar bridge. Each phase output is either sourcing (upper switch on), sinking (lower switch on) or released (both off). Motor power is set by pulse-width modulating only the lower switch of the energized pair. The upper switch of that pair stays on for the whole commutation step.

A free-running carrier counter with a programmable period compares against a digital duty command. The duty command is halved while the speed loop reports phase lock. A peak-current flag ends the lower-switch on time early for the rest of the carrier period. The flag is not looked at during a blanking window at the start of each on time, so diode recovery spikes cannot trip it. A start/stop input and a braking request are also handled. During braking, a select input chooses between coasting with all switches off and reverse-torque drive, which swaps which phase sources and which sinks. A protection input turns off every lower switch.

Top module: `hall_bridge_ctrl`

## Requirements
- R1: With hall = {IN1,IN2,IN3} (bit 2 is IN1, 1 means IN+ above IN-), running and not braking, the drive per phase (P = upper on, N = lower on, - = off) for phases 1,2,3 is: 101→N,P,-; 100→N,-,P; 110→-,N,P; 010→P,N,-; 011→P,-,N; 001→-,P,N. No phase ever has both switches on.
- R2: Hall codes 000 and 111 turn every switch off.
- R3: While run_n is high (stopped), every switch is off.
- R4: While brake is high and coast_sel is high, every switch is off.
- R5: While brake is high and coast_sel is low, the sourcing phase and the sinking phase of the R1 table swap roles.
- R6: The carrier counts 0 to period-1 and repeats. The lower switch conducts while the count is below the scaled duty, so it is on for min(scaled duty, period) cycles of each period. The upper switch is never modulated.
- R7: The scaled duty is duty shifted right by one while locked is high, and duty unchanged while it is low.
- R8: If ilim is high in a cycle whose count is at least BLANK_CYC and the lower switch is on, the lower switch is off from the next cycle until the carrier wraps. ilim is ignored in cycles whose count is below BLANK_CYC.
- R9: While prot_off is high, every lower switch is off and the upper switch follows R1.
- R10: While rst_n is low, every switch is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hall | input | 3 | Digitized Hall levels {IN1,IN2,IN3} |
| run_n | input | 1 | Low runs, high stops |
| brake | input | 1 | Braking request |
| coast_sel | input | 1 | High: coast when braking; low: reverse torque |
| locked | input | 1 | Speed loop phase lock, halves the duty |
| duty | input | CNT_W | Duty command in carrier counts |
| period | input | CNT_W | Carrier period in clock cycles |
| ilim | input | 1 | Peak-current flag |
| prot_off | input | 1 | Forces all lower switches off |
| hi_on | output | 3 | Upper switch commands, bit 0 = phase 1 |
| lo_on | output | 3 | Lower switch commands, bit 0 = phase 1 |

## Verification
The commutation logic is swept over all eight Hall codes crossed with every run, brake and coast combination at full duty. This separates the legal table, the illegal codes, the stop state, coasting and the swapped reverse-torque drive. Duty is then swept past the carrier period, both locked and unlocked. The on-cycles per period are counted, which shows the compare edge, saturation at full duty and the halving. A held current flag checks that the on time is cut to exactly the blanking window plus one cycle. A protection run shows that the lower switches drop while the upper switches keep their pattern.

// File: rtl/hall_bridge_ctrl.sv
module hall_bridge_ctrl #(
  parameter int CNT_W     = 8,
  parameter int BLANK_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       hall,
  input  logic             run_n,
  input  logic             brake,
  input  logic             coast_sel,
  input  logic             locked,
  input  logic [CNT_W-1:0] duty,
  input  logic [CNT_W-1:0] period,
  input  logic             ilim,
  input  logic             prot_off,
  output logic [2:0]       hi_on,
  output logic [2:0]       lo_on
);
  localparam logic [CNT_W-1:0] BLANK_V = CNT_W'(BLANK_CYC);

  logic [CNT_W-1:0] cnt;
  logic             trip;
  logic [2:0]       src, snk;

  always_comb begin
    src = 3'b000;
    snk = 3'b000;
    case (hall)
      3'b101: begin snk = 3'b001; src = 3'b010; end
      3'b100: begin snk = 3'b001; src = 3'b100; end
      3'b110: begin snk = 3'b010; src = 3'b100; end
      3'b010: begin src = 3'b001; snk = 3'b010; end
      3'b011: begin src = 3'b001; snk = 3'b100; end
      3'b001: begin src = 3'b010; snk = 3'b100; end
      default: ;
    endcase
  end

  wire [CNT_W-1:0] dscaled = locked ? (duty >> 1) : duty;
  wire             wrap    = ({1'b0, cnt} + 1'b1) >= {1'b0, period};
  wire             pwm_on  = cnt < dscaled;
  wire             active  = rst_n && !run_n && !(brake && coast_sel);
  wire             rev     = brake && !coast_sel;
  wire             lo_gate = pwm_on && !trip && !prot_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      trip <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      trip <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      if (ilim && pwm_on && cnt >= BLANK_V) trip <= 1'b1;
    end
  end

  assign hi_on = active ? (rev ? snk : src) : 3'b000;
  assign lo_on = (active && lo_gate) ? (rev ? src : snk) : 3'b000;

  p_no_shoot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_on & lo_on) == 3'b000 && $onehot0(hi_on) && $onehot0(lo_on));
  p_stop_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_n |-> (hi_on == 3'b000 && lo_on == 3'b000));
  p_coast_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (brake && coast_sel) |-> (hi_on == 3'b000 && lo_on == 3'b000));
  p_prot_low_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    prot_off |-> lo_on == 3'b000);
  p_blank_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt < BLANK_V) |-> !trip);
  p_trip_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trip && !wrap) |=> trip);
  p_carrier_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == '0);
endmodule

// File: tb/hall_bridge_ctrl_bench.sv
module hall_bridge_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int W = 8;
  localparam int BLANK = 4;

  logic clk = 0, rst_n = 0;
  logic [2:0] hall = 3'b101;
  logic run_n = 0, brake = 0, coast_sel = 1, locked = 0, ilim = 0, prot_off = 0;
  logic [W-1:0] duty = 8'd255, period = 8'd16;
  logic [2:0] hi_on, lo_on;
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  hall_bridge_ctrl #(.CNT_W(W), .BLANK_CYC(BLANK)) u_hall_bridge_ctrl (
    .clk(clk), .rst_n(rst_n), .hall(hall), .run_n(run_n), .brake(brake),
    .coast_sel(coast_sel), .locked(locked), .duty(duty), .period(period),
    .ilim(ilim), .prot_off(prot_off), .hi_on(hi_on), .lo_on(lo_on));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void table_of(input logic [2:0] h, output logic [2:0] s, output logic [2:0] k);
    s = 0; k = 0;
    case (h)
      3'b101: begin k = 3'b001; s = 3'b010; end
      3'b100: begin k = 3'b001; s = 3'b100; end
      3'b110: begin k = 3'b010; s = 3'b100; end
      3'b010: begin s = 3'b001; k = 3'b010; end
      3'b011: begin s = 3'b001; k = 3'b100; end
      3'b001: begin s = 3'b010; k = 3'b100; end
      default: ;
    endcase
  endfunction

  task automatic count_on(input int n, output int on, output int hi_bad);
    on = 0; hi_bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (lo_on != 0) on++;
      if (hi_on != 3'b010) hi_bad++;
    end
  endtask

  initial begin
    #(CLK_P*20000);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [2:0] s, k, eh, el;
    int on, hb, exp;
    @(negedge clk);
    chk("R10 hi", hi_on, 0);
    chk("R10 lo", lo_on, 0);
    rst_n = 1;
    for (int h = 0; h < 8; h++)
      for (int m = 0; m < 8; m++) begin
        hall = 3'(h); run_n = m[0]; brake = m[1]; coast_sel = m[2];
        @(negedge clk);
        table_of(3'(h), s, k);
        if (run_n || (brake && coast_sel)) begin eh = 0; el = 0; end
        else if (brake) begin eh = k; el = s; end
        else begin eh = s; el = k; end
        if (h == 0 || h == 7) chk("R2 illegal", {hi_on, lo_on}, 0);
        else if (run_n) chk("R3 stop", {hi_on, lo_on}, 0);
        else if (brake && coast_sel) chk("R4 coast", {hi_on, lo_on}, 0);
        else if (brake) chk("R5 reverse", {hi_on, lo_on}, {eh, el});
        else chk("R1 table", {hi_on, lo_on}, {eh, el});
      end
    hall = 3'b101; run_n = 0; brake = 0; coast_sel = 1; period = 8'd10;
    for (int lk = 0; lk < 2; lk++)
      for (int d = 0; d <= 12; d++) begin
        locked = lk[0]; duty = 8'(d);
        count_on(10, on, hb);
        count_on(10, on, hb);
        exp = lk ? d / 2 : d;
        if (exp > 10) exp = 10;
        chk(lk ? "R7 locked scale" : "R6 duty compare", on, exp);
        chk("R6 upper steady", hb, 0);
      end
    locked = 0; duty = 8'd20; period = 8'd20; ilim = 1;
    count_on(20, on, hb);
    count_on(20, on, hb);
    chk("R8 limit after blank", on, BLANK + 1);
    count_on(20, on, hb);
    chk("R8 limit repeats", on, BLANK + 1);
    ilim = 0;
    count_on(20, on, hb);
    count_on(20, on, hb);
    chk("R8 released", on, 20);
    prot_off = 1;
    count_on(20, on, hb);
    chk("R9 lower off", on, 0);
    chk("R9 upper kept", hb, 0);
    prot_off = 0;
    rst_n = 0;
    @(negedge clk);
    chk("R10 reset again", {hi_on, lo_on}, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule